// File: doc/BRIEF.md
# Multi-Channel Serial Register Command Decoder

This block sits behind a byte-wide serial link and turns programming commands into register accesses for a four-channel device. Every transaction opens with one command byte. Its top bit picks write (1) or read (0). The next two bits pick the target, and the low five bits give a location. Each channel has its own bank of 32 local registers, and one global bank is shared by all channels. Global register 4 holds the channel-enable mask in its low four bits.

A local command starts at the given address and then steps down by one after every byte, down to and including address 0. A local write goes to every enabled channel at the same moment. A local write is committed only once its last byte has arrived, so dropping the select line part way through leaves every register as it was. A local read needs exactly one enabled channel. Every accepted read answers first with the tag byte 0x81 and then with its data bytes, one byte per cycle.

Top module: `chcmd_decoder`

## Requirements
- R1: After reset all local and global registers read as zero, the enable mask is 0, and tx_valid, err and done are low.
- R2: A command byte is split as follows. Bit 7 is 1 for write and 0 for read. Bits 6:5 give the kind: 00 local, 01 global, 10 single-word tone RAM, 11 eight-word coefficient RAM. Bits 4:0 give the address A.
- R3: A local write with address A takes A+1 data bytes. The first byte goes to register A, and each later byte goes to the next lower address, ending at 0. The same bytes are stored in every channel whose enable bit is set.
- R4: A local write leaves unchanged every channel whose enable bit is clear. The enable mask is bits 3:0 of global register 4, with bit n enabling channel n.
- R5: A global write takes one data byte and stores it at global address A. A global read returns 0x81 followed by that register.
- R6: A local read with exactly one enabled channel puts 0x81 on tx in the cycle after the command byte is taken. It then sends registers A, A-1, …, 0 of that channel, one per cycle.
- R7: A local read with zero enabled channels, or with more than one, pulses err for one cycle after the command byte and sends no bytes.
- R8: A tone RAM command moves exactly one data byte and a coefficient RAM command moves exactly eight. Written RAM bytes are consumed without changing any register. A RAM read returns 0x81 followed by that many zero bytes.
- R9: If cs goes low before the last data byte of a write, the command is abandoned and no register changes. The next byte taken with cs high is decoded as a new command.
- R10: done pulses for one cycle after the edge that takes the last byte of a write, or after the edge that ends the last byte of a read response.
- R11: Bytes that arrive while a read response is being sent are ignored.
- R12: If cs goes low during a read response, tx_valid is low from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Transaction frame, high while a command is in progress |
| rx_valid | input | 1 | Byte strobe for rx_byte |
| rx_byte | input | 8 | Incoming command or data byte |
| tx_valid | output | 1 | Response byte valid |
| tx_byte | output | 8 | Response byte (tag 0x81 first) |
| err | output | 1 | One-cycle pulse when a read is rejected |
| done | output | 1 | One-cycle pulse when a command completes |

## Verification
The hardest cases to reach from the ports are a broadcast write whose bytes must be found in some channels and missing from others, and a write abandoned before its last byte. Neither one shows up on tx until the mask is set back to a single channel and each bank is read out. The stimulus therefore reprograms global register 4 between writes and reads, both in directed steps and at random. It also drops cs in the middle of a multi-byte write and then reads back every channel that could have been touched.

// File: rtl/chcmd_pkg.sv
package chcmd_pkg;

  typedef enum logic [1:0] {
    CK_LOCAL  = 2'b00,
    CK_GLOBAL = 2'b01,
    CK_TONE   = 2'b10,
    CK_COEF   = 2'b11
  } cmd_kind_e;

  typedef struct packed {
    logic      wr;
    cmd_kind_e kind;
    logic [4:0] addr;
  } cmd_t;

  localparam int unsigned COEF_WORDS = 8;

  // index of the last byte in a burst (bytes = value + 1)
  function automatic logic [4:0] burst_last(input cmd_t c);
    case (c.kind)
      CK_LOCAL: burst_last = c.addr;
      CK_COEF:  burst_last = 5'(COEF_WORDS - 1);
      default:  burst_last = 5'd0;
    endcase
  endfunction

  function automatic int unsigned ones_of(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) n += v[i] ? 1 : 0;
    return n;
  endfunction

  function automatic int unsigned first_set(input logic [31:0] v);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) if (v[i]) r = i;
    return r;
  endfunction

endpackage

// File: rtl/chcmd_lbank.sv
module chcmd_lbank #(
  parameter int DW   = 8,
  parameter int AW   = 5,
  parameter int NREG = 1 << AW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wen,
  input  logic [AW-1:0]        top,
  input  logic [NREG*DW-1:0]   wdata,
  input  logic [AW-1:0]        raddr,
  output logic [DW-1:0]        rdata
);
  logic [NREG*DW-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
    end else if (wen) begin
      for (int i = 0; i < NREG; i++)
        if (AW'(i) <= top) mem[i*DW +: DW] <= wdata[i*DW +: DW];
    end
  end

  assign rdata = mem[raddr*DW +: DW];

  assert_disabled_bank_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wen |=> $stable(mem));
endmodule

// File: rtl/chcmd_gbank.sv
module chcmd_gbank #(
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int NCH      = 4,
  parameter int ENA_ADDR = 4,
  parameter int NREG     = 1 << AW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [AW-1:0]  raddr,
  output logic [DW-1:0]  rdata,
  output logic [NCH-1:0] ena_mask
);
  logic [NREG*DW-1:0] mem;

  always_ff @(posedge clk) begin
    if (!rst_n) mem <= '0;
    else if (we) mem[waddr*DW +: DW] <= wdata;
  end

  assign rdata    = mem[raddr*DW +: DW];
  assign ena_mask = mem[ENA_ADDR*DW +: NCH];

  assert_global_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(mem));
endmodule

// File: rtl/chcmd_ctrl.sv
module chcmd_ctrl
  import chcmd_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int DW   = 8,
  parameter int AW   = 5,
  parameter int NREG = 1 << AW,
  parameter int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs,
  input  logic               rx_valid,
  input  logic [7:0]         rx_byte,
  input  logic [NCH-1:0]     ena_mask,
  output logic               tx_active,
  output logic               tx_id,
  output cmd_kind_e          kind_q,
  output logic [AW-1:0]      addr_q,
  output logic [AW-1:0]      cnt,
  output logic [CW-1:0]      sel_ch,
  output logic               lcommit,
  output logic [NCH-1:0]     mask_q,
  output logic [NREG*DW-1:0] stage_flat,
  output logic               gwe,
  output logic [DW-1:0]      gdata,
  output logic               err,
  output logic               done
);
  typedef enum logic [1:0] {S_IDLE, S_WR, S_ID, S_RD} st_e;
  st_e st;
  logic [DW-1:0] stage [NREG];
  cmd_t cin;
  int unsigned n_en;

  assign cin  = cmd_t'(rx_byte);
  assign n_en = ones_of(32'(ena_mask));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; kind_q <= CK_LOCAL; addr_q <= '0; cnt <= '0;
      sel_ch <= '0; mask_q <= '0; lcommit <= 1'b0; gwe <= 1'b0;
      gdata <= '0; err <= 1'b0; done <= 1'b0;
      for (int i = 0; i < NREG; i++) stage[i] <= '0;
    end else begin
      lcommit <= 1'b0; gwe <= 1'b0; err <= 1'b0; done <= 1'b0;
      if (!cs) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: if (rx_valid) begin
            kind_q <= cin.kind;
            addr_q <= AW'(cin.addr);
            cnt    <= AW'(burst_last(cin));
            mask_q <= ena_mask;
            sel_ch <= CW'(first_set(32'(ena_mask)));
            if (cin.wr) st <= S_WR;
            else if (cin.kind == CK_LOCAL && n_en != 1) err <= 1'b1;
            else st <= S_ID;
          end
          S_WR: if (rx_valid) begin
            if (kind_q == CK_LOCAL) stage[cnt] <= rx_byte;
            if (cnt == '0) begin
              st   <= S_IDLE;
              done <= 1'b1;
              if (kind_q == CK_LOCAL)  lcommit <= 1'b1;
              if (kind_q == CK_GLOBAL) begin gwe <= 1'b1; gdata <= rx_byte; end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
          S_ID: st <= S_RD;
          S_RD: begin
            if (cnt == '0) begin st <= S_IDLE; done <= 1'b1; end
            else cnt <= cnt - 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_stage
    assign stage_flat[g*DW +: DW] = stage[g];
  end

  assign tx_active = (st == S_ID) || (st == S_RD);
  assign tx_id     = (st == S_ID);

  assert_abort_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> st == S_IDLE);
  assert_read_one_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ID && kind_q == CK_LOCAL) |-> $countones(mask_q) == 1);
  assert_countdown_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD && $past(st) == S_RD && cs && $past(cs)) |-> cnt == $past(cnt) - 1'b1);
  assert_err_done_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && done));
endmodule

// File: rtl/chcmd_decoder.sv
module chcmd_decoder
  import chcmd_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int ENA_ADDR = 4,
  parameter logic [7:0] TAG = 8'h81
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       err,
  output logic       done
);
  localparam int NREG = 1 << AW;
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1;

  logic               tx_active, tx_id, lcommit, gwe;
  cmd_kind_e          kind_q;
  logic [AW-1:0]      addr_q, cnt;
  logic [CW-1:0]      sel_ch;
  logic [NCH-1:0]     mask_q, ena_mask;
  logic [NREG*DW-1:0] stage_flat;
  logic [DW-1:0]      gdata, grd;
  logic [DW-1:0]      lrd [NCH];
  logic [DW-1:0]      data_sel;

  chcmd_ctrl #(.NCH(NCH), .DW(DW), .AW(AW)) u_ctrl (
    .clk, .rst_n, .cs, .rx_valid, .rx_byte, .ena_mask,
    .tx_active, .tx_id, .kind_q, .addr_q, .cnt, .sel_ch,
    .lcommit, .mask_q, .stage_flat, .gwe, .gdata, .err, .done
  );

  chcmd_gbank #(.DW(DW), .AW(AW), .NCH(NCH), .ENA_ADDR(ENA_ADDR)) u_gbank (
    .clk, .rst_n, .we(gwe), .waddr(addr_q), .wdata(gdata),
    .raddr(addr_q), .rdata(grd), .ena_mask
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    chcmd_lbank #(.DW(DW), .AW(AW)) u_lbank (
      .clk, .rst_n, .wen(lcommit && mask_q[c]), .top(addr_q),
      .wdata(stage_flat), .raddr(cnt), .rdata(lrd[c])
    );
  end

  always_comb begin
    case (kind_q)
      CK_LOCAL:  data_sel = lrd[sel_ch];
      CK_GLOBAL: data_sel = grd;
      default:   data_sel = '0;
    endcase
  end

  assign tx_valid = tx_active;
  assign tx_byte  = tx_id ? TAG : 8'(data_sel);

  assert_tag_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> tx_byte == TAG);
  assert_reject_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !tx_valid);
endmodule

// File: tb/chcmd_decoder_bench.sv
module chcmd_decoder_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic tx_valid, err, done;
  logic [7:0] tx_byte;

  int nvec = 0, nbad = 0;
  bit finished = 0;
  logic [7:0] lreg [4][32];
  logic [7:0] greg [32];
  logic [7:0] wbuf [32];

  chcmd_decoder u_chcmd_decoder (.clk, .rst_n, .cs, .rx_valid, .rx_byte,
                                 .tx_valid, .tx_byte, .err, .done);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mk(bit wr, int kind, int addr);
    return {wr, 2'(kind), 5'(addr)};
  endfunction
  function automatic int burst(int kind, int addr);
    return kind == 0 ? addr + 1 : (kind == 3 ? 8 : 1);
  endfunction
  function automatic int mask_ones();
    int n = 0;
    for (int c = 0; c < 4; c++) n += greg[4][c] ? 1 : 0;
    return n;
  endfunction
  function automatic int low_ch();
    for (int c = 3; c >= 0; c--) if (greg[4][c]) low_ch = c;
  endfunction

  task automatic chk(bit ok, string req, logic [7:0] act, logic [7:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); cs = 1'b1; rx_valid = 1'b1; rx_byte = b;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  // write command: wbuf[0..n-1] are the data bytes
  task automatic wr_cmd(int kind, int addr);
    int n = burst(kind, addr);
    push(mk(1, kind, addr));
    for (int i = 0; i < n; i++) push(wbuf[i]);
    chk(done === 1'b1, "R10 write done", {7'd0, done}, 8'd1);
    if (kind == 0) begin
      for (int c = 0; c < 4; c++)
        if (greg[4][c]) for (int i = 0; i < n; i++) lreg[c][addr - i] = wbuf[i];
    end else if (kind == 1) greg[addr] = wbuf[0];
  endtask

  task automatic rd_cmd(int kind, int addr, bit junk);
    int n = burst(kind, addr);
    logic [7:0] exp;
    @(negedge clk); cs = 1'b1; rx_valid = 1'b1; rx_byte = mk(0, kind, addr);
    @(negedge clk); rx_valid = 1'b0;
    if (kind == 0 && mask_ones() != 1) begin
      chk(err === 1'b1, "R7 err pulse", {7'd0, err}, 8'd1);
      chk(tx_valid === 1'b0, "R7 no bytes", {7'd0, tx_valid}, 8'd0);
      @(negedge clk);
      chk(tx_valid === 1'b0, "R7 still silent", {7'd0, tx_valid}, 8'd0);
      return;
    end
    chk(tx_valid === 1'b1 && tx_byte === 8'h81, "R6 tag byte", tx_byte, 8'h81);
    for (int k = n - 1; k >= 0; k--) begin
      if (junk) begin rx_valid = 1'b1; rx_byte = 8'($urandom); end  // R11
      @(negedge clk);
      if (kind == 0) exp = lreg[low_ch()][k];
      else if (kind == 1) exp = greg[addr];
      else exp = 8'h00;
      chk(tx_valid === 1'b1 && tx_byte === exp,
          kind == 0 ? "R6 local data" : (kind == 1 ? "R5 global data" : "R8 ram data"),
          tx_byte, exp);
    end
    rx_valid = 1'b0;
    @(negedge clk);
    chk(done === 1'b1 && tx_valid === 1'b0, "R10 read done", {6'd0, done, tx_valid}, 8'd2);
  endtask

  task automatic set_mask(logic [7:0] m);
    wbuf[0] = m;
    wr_cmd(1, 4);
  endtask

  task automatic read_all_ch(int addr);
    for (int c = 0; c < 4; c++) begin
      set_mask(8'(1 << c));
      rd_cmd(0, addr, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nbad++; nvec++;
      $display("FAIL watchdog actual=%h expected=%h", 8'd0, 8'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd915);
    for (int c = 0; c < 4; c++) for (int a = 0; a < 32; a++) lreg[c][a] = '0;
    for (int a = 0; a < 32; a++) greg[a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tx_valid === 1'b0 && err === 1'b0 && done === 1'b0, "R1 idle outputs",
        {5'd0, tx_valid, err, done}, 8'd0);
    rd_cmd(0, 0, 0);                    // R1/R7: mask zero after reset -> rejected
    rd_cmd(1, 4, 0);                    // R1: mask register reads zero
    set_mask(8'h01);
    rd_cmd(0, 31, 0);                   // R1: all of channel 0 zero
    // R3/R4 broadcast write to channels 0,1,3
    set_mask(8'h0B);
    for (int i = 0; i < 4; i++) wbuf[i] = 8'hA0 + 8'(i);
    wr_cmd(0, 3);                       // R2 local write decode
    rd_cmd(0, 3, 0);                    // R7: several channels -> rejected
    read_all_ch(5);                     // R3 stored, R4 channel 2 untouched
    // R5 global
    wbuf[0] = 8'h5C; wr_cmd(1, 9); rd_cmd(1, 9, 0);
    // R8 RAM commands leave registers alone
    for (int i = 0; i < 8; i++) wbuf[i] = 8'hEE;
    wr_cmd(3, 0); wbuf[0] = 8'h77; wr_cmd(2, 6);
    rd_cmd(3, 2, 0); rd_cmd(2, 1, 0);
    read_all_ch(3);
    // R9 abort mid-write
    set_mask(8'h0F);
    push(mk(1, 0, 5)); push(8'h11); push(8'h22);
    @(negedge clk); cs = 1'b0;
    @(negedge clk); cs = 1'b1;
    read_all_ch(5);
    // R11 junk bytes during a response
    rd_cmd(0, 7, 1);
    // R12 cs low during a response
    @(negedge clk); rx_valid = 1'b1; rx_byte = mk(0, 0, 20);
    @(negedge clk); rx_valid = 1'b0;
    chk(tx_valid === 1'b1 && tx_byte === 8'h81, "R12 response started", tx_byte, 8'h81);
    cs = 1'b0;
    @(negedge clk);
    chk(tx_valid === 1'b0, "R12 stopped", {7'd0, tx_valid}, 8'd0);
    @(negedge clk); cs = 1'b1;
    // random mix
    for (int it = 0; it < 60; it++) begin
      int op, a;
      op = int'($urandom % 6);
      a  = int'($urandom % 32);
      case (op)
        0: set_mask(($urandom % 2) ? 8'(1 << ($urandom % 4)) : 8'($urandom));
        1: begin for (int i = 0; i <= a; i++) wbuf[i] = 8'($urandom); wr_cmd(0, a); end
        2: rd_cmd(0, a, bit'($urandom % 2));
        3: begin wbuf[0] = 8'($urandom); wr_cmd(1, a); end
        4: rd_cmd(1, a, 0);
        default: begin
          for (int i = 0; i < 8; i++) wbuf[i] = 8'($urandom);
          if ($urandom % 2) wr_cmd(2 + int'($urandom % 2), a);
          else rd_cmd(2 + int'($urandom % 2), a, 0);
        end
      endcase
    end
    read_all_ch(31);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule